// File: doc/BRIEF.md
# Dual Parallel Port GPIO Controller

This block gives a host 48 general-purpose I/O lines behind a byte-wide register window of eight addresses. The lines form two independent groups of 24, and each group acts like a simple-mode parallel interface. A group has three 8-bit ports and one control register. The third port of each group splits into an upper and a lower nibble, and each nibble has its own direction. Handshake modes, interrupts and strobed transfers are not supported.

The host uses a synchronous bus with a 3-bit address, write data, read data, a write strobe and a read strobe. Address bit 2 selects the group. Address bits 1:0 select port A (0), port B (1), port C (2) or the control register (3). A control write with bit 7 set is a direction word. A control write with bit 7 clear sets or clears a single bit of port C. For every pin the block drives an output value and an output-enable, and it samples the pin's input level.

Each group applies its writes through a write-kind decode with four named kinds:
- `WK_IDLE`: no write to this group.
- `WK_PORT`: a port latch is loaded.
- `WK_MODE`: the direction word is stored and the group's latches are cleared.
- `WK_BIT`: one bit of port C is set or cleared.

Each cycle moves from the decoded kind straight to that kind's register update, and the kind for the next cycle is decoded afresh. No state is kept between writes except the latches and the control register.

Top module: `dpio_ctrl`

## Requirements
- R1: After reset, every pin_oe bit is 0 and every pin_out bit is 0, and both control registers (addresses 3 and 7) read 0x9B.
- R2: Addresses 0, 1 and 2 reach ports A, B and C of group 0, which drive pins 0-7, 8-15 and 16-23. Addresses 4, 5 and 6 reach the same ports of group 1, which drive pins 24-47. Address 3 is the group 0 control register and address 7 is the group 1 control register.
- R3: In a control write with bit 7 set, each direction bit makes its field an input when 1 and an output when 0. Bit 4 sets port A, bit 1 sets port B, bit 3 sets port C bits 7:4, and bit 0 sets port C bits 3:0. The pin_oe bit of each pin is the inverse of its direction bit.
- R4: Writing 0x80 to a control register sets all 24 pin_oe bits of that group to 1.
- R5: A port write loads that port's 8-bit latch on the next clock edge. pin_out always shows the latch. Only pins configured as outputs have pin_oe set.
- R6: A read returns, on the cycle after the read strobe, the pin level for each input bit and the latch value for each output bit.
- R7: A direction-word write clears all three latches of its own group to 0 on the same edge that the new directions take effect. The other group's latches and directions do not change.
- R8: Bits 6, 5 and 2 of a direction word have no effect on direction. A control read returns the whole last direction word, including those bits.
- R9: A control write with bit 7 clear sets port C bit wdata[3:1] of that group to wdata[0]. It leaves the control register, the directions and every other latch bit unchanged.
- R10: bus_rdata holds its value in any cycle without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register address within the 8-byte window |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data, valid the cycle after bus_rd |
| pin_in | input | 48 | Sampled pin levels |
| pin_out | output | 48 | Output latch value for each pin |
| pin_oe | output | 48 | Output enable for each pin, 1 = drive |

## Verification
Direction words are tried in several forms: the all-output word, the all-input reset word, a word that splits port C between its nibbles, and a word with the ignored bits set. Each form is followed by reads while pin_in carries a pattern that differs from the latches, so every bit shows whether it came from the pin or from the latch. Writes to the two groups are interleaved, which separates a clear confined to one group from a clear that reaches both. Bit operations on port C set and clear bits at both ends of the byte, which exposes a wrong bit index or a change to a neighbouring bit.

// File: rtl/dpio_pkg.sv
package dpio_pkg;
    // Control register value after reset: every field an input.
    localparam logic [7:0] CTRL_RESET = 8'h9B;

    // Kind of write seen by one group in the current cycle.
    typedef enum logic [1:0] {
        WK_IDLE,
        WK_PORT,
        WK_MODE,
        WK_BIT
    } wr_kind_e;
endpackage

// File: rtl/dpio_group.sv
module dpio_group
    import dpio_pkg::*;
#(
    parameter int PORT_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                wr_en,
    input  logic [1:0]          sel,
    input  logic [PORT_W-1:0]   wdata,
    input  logic [3*PORT_W-1:0] pin_in,
    output logic [3*PORT_W-1:0] pin_out,
    output logic [3*PORT_W-1:0] pin_oe,
    output logic [PORT_W-1:0]   rd_view
);
    localparam int HALF  = PORT_W / 2;
    localparam int BIT_W = $clog2(PORT_W);

    logic [PORT_W-1:0]   ctrl_q;
    logic [PORT_W-1:0]   lat_q [3];
    logic [3*PORT_W-1:0] dir;      // 1 = input
    logic [3*PORT_W-1:0] mixed;
    wr_kind_e            kind;

    // Direction fields taken from the stored direction word.
    assign dir = {{HALF{ctrl_q[3]}}, {(PORT_W-HALF){ctrl_q[0]}},
                  {PORT_W{ctrl_q[1]}}, {PORT_W{ctrl_q[4]}}};

    // Decode the kind of write.
    always_comb begin
        kind = WK_IDLE;
        if (wr_en) begin
            if (sel == 2'd3) kind = wdata[7] ? WK_MODE : WK_BIT;
            else             kind = WK_PORT;
        end
    end

    // State register process.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= CTRL_RESET;
            for (int p = 0; p < 3; p++) lat_q[p] <= '0;
        end else begin
            unique case (kind)
                WK_IDLE: ;
                WK_PORT: begin
                    case (sel)
                        2'd0:    lat_q[0] <= wdata;
                        2'd1:    lat_q[1] <= wdata;
                        default: lat_q[2] <= wdata;
                    endcase
                end
                WK_MODE: begin
                    ctrl_q <= wdata;
                    for (int p = 0; p < 3; p++) lat_q[p] <= '0;
                end
                WK_BIT: lat_q[2][wdata[BIT_W:1]] <= wdata[0];
                default: ;
            endcase
        end
    end

    // Output process: pin drive and read view.
    genvar gp;
    generate
        for (gp = 0; gp < 3; gp++) begin : g_port
            assign pin_out[gp*PORT_W +: PORT_W] = lat_q[gp];
            assign mixed[gp*PORT_W +: PORT_W] =
                (pin_in[gp*PORT_W +: PORT_W] & dir[gp*PORT_W +: PORT_W]) |
                (lat_q[gp] & ~dir[gp*PORT_W +: PORT_W]);
        end
    endgenerate

    assign pin_oe = ~dir;

    always_comb begin
        unique case (sel)
            2'd0:    rd_view = mixed[0 +: PORT_W];
            2'd1:    rd_view = mixed[PORT_W +: PORT_W];
            2'd2:    rd_view = mixed[2*PORT_W +: PORT_W];
            default: rd_view = ctrl_q;
        endcase
    end
endmodule

// File: rtl/dpio_rd_stage.sv
module dpio_rd_stage #(
    parameter int PORT_W     = 8,
    parameter int NUM_GROUPS = 2
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                rd,
    input  logic [$clog2(NUM_GROUPS)-1:0]       grp,
    input  logic [NUM_GROUPS-1:0][PORT_W-1:0]   views,
    output logic [PORT_W-1:0]                   rdata
);
    always_ff @(posedge clk) begin
        if (!rst_n)  rdata <= '0;
        else if (rd) rdata <= views[grp];
    end
endmodule

// File: rtl/dpio_ctrl.sv
module dpio_ctrl #(
    parameter int PORT_W     = 8,
    parameter int NUM_GROUPS = 2,
    localparam int GRP_W     = $clog2(NUM_GROUPS),
    localparam int ADDR_W    = GRP_W + 2,
    localparam int LINES     = NUM_GROUPS * 3 * PORT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PORT_W-1:0] bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [PORT_W-1:0] bus_rdata,
    input  logic [LINES-1:0]  pin_in,
    output logic [LINES-1:0]  pin_out,
    output logic [LINES-1:0]  pin_oe
);
    localparam int G_LINES = 3 * PORT_W;

    logic [NUM_GROUPS-1:0][PORT_W-1:0] views;
    logic [GRP_W-1:0]                  grp;

    assign grp = bus_addr[ADDR_W-1:2];

    genvar g;
    generate
        for (g = 0; g < NUM_GROUPS; g++) begin : g_grp
            dpio_group #(.PORT_W(PORT_W)) u_group (
                .clk     (clk),
                .rst_n   (rst_n),
                .wr_en   (bus_wr && (grp == GRP_W'(g))),
                .sel     (bus_addr[1:0]),
                .wdata   (bus_wdata),
                .pin_in  (pin_in[g*G_LINES +: G_LINES]),
                .pin_out (pin_out[g*G_LINES +: G_LINES]),
                .pin_oe  (pin_oe[g*G_LINES +: G_LINES]),
                .rd_view (views[g])
            );
        end
    endgenerate

    dpio_rd_stage #(.PORT_W(PORT_W), .NUM_GROUPS(NUM_GROUPS)) u_rd (
        .clk   (clk),
        .rst_n (rst_n),
        .rd    (bus_rd),
        .grp   (grp),
        .views (views),
        .rdata (bus_rdata)
    );
endmodule

// File: rtl/dpio_ctrl_chk.sv
module dpio_ctrl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [2:0]  bus_addr,
    input logic [7:0]  bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic [7:0]  bus_rdata,
    input logic [47:0] pin_out,
    input logic [47:0] pin_oe
);
    // R10: read data is held without a read strobe
    a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd |=> $stable(bus_rdata));

    // R5: a write to port A of group 0 appears on its pins next cycle
    a_r5_port_load: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd0) |=> (pin_out[7:0] == $past(bus_wdata)));

    // R7: a direction word on group 0 clears its latches
    a_r7_clear_own: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3 && bus_wdata[7]) |=> (pin_out[23:0] == 24'd0));

    // R7: a direction word on group 0 leaves group 1 alone
    a_r7_other_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd3 && bus_wdata[7]) |=>
            ($stable(pin_out[47:24]) && $stable(pin_oe[47:24])));

    // R4: writing 0x80 turns every line of group 1 into an output
    a_r4_all_out: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 3'd7 && bus_wdata == 8'h80) |=> (pin_oe[47:24] == '1));

    // R9: a bit operation does not change directions
    a_r9_bit_keeps_dir: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr[1:0] == 2'd3 && !bus_wdata[7]) |=> $stable(pin_oe));
endmodule

bind dpio_ctrl dpio_ctrl_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_rdata (bus_rdata),
    .pin_out   (pin_out),
    .pin_oe    (pin_oe)
);

// File: tb/dpio_ctrl_bench.sv
`timescale 1ns/1ps
module dpio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  bus_addr = '0;
    logic [7:0]  bus_wdata = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_rdata;
    logic [47:0] pin_in = '0;
    logic [47:0] pin_out;
    logic [47:0] pin_oe;

    int n_tests = 0;
    int n_fail  = 0;

    // Reference model state
    logic [7:0] m_lat [6];
    logic [7:0] m_ctl [2];
    logic [7:0] m_rd;

    always #5 clk = ~clk;

    dpio_ctrl u_dpio_ctrl (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
        .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
    );

    function automatic logic [23:0] m_dir(input int g);
        logic [7:0] c;
        c = m_ctl[g];
        return {{4{c[3]}}, {4{c[0]}}, {8{c[1]}}, {8{c[4]}}};
    endfunction

    function automatic logic [47:0] m_oe();
        return ~{m_dir(1), m_dir(0)};
    endfunction

    function automatic logic [47:0] m_out();
        return {m_lat[5], m_lat[4], m_lat[3], m_lat[2], m_lat[1], m_lat[0]};
    endfunction

    function automatic logic [7:0] m_read(input logic [2:0] a, input logic [47:0] pins);
        int g, s;
        logic [23:0] d, l, p;
        g = a[2];
        s = a[1:0];
        if (s == 3) return m_ctl[g];
        d = m_dir(g);
        l = {m_lat[g*3+2], m_lat[g*3+1], m_lat[g*3]};
        p = pins[g*24 +: 24];
        return ((p & d) | (l & ~d)) >> (s*8);
    endfunction

    task automatic check(input string tag);
        n_tests += 3;
        if (pin_out !== m_out()) begin
            n_fail++;
            $display("FAIL %s pin_out actual=%h expected=%h", tag, pin_out, m_out());
        end
        if (pin_oe !== m_oe()) begin
            n_fail++;
            $display("FAIL %s pin_oe actual=%h expected=%h", tag, pin_oe, m_oe());
        end
        if (bus_rdata !== m_rd) begin
            n_fail++;
            $display("FAIL %s bus_rdata actual=%h expected=%h", tag, bus_rdata, m_rd);
        end
    endtask

    // One bus cycle: drive at negedge, update the model at posedge, compare at next negedge.
    task automatic cycle(input logic [2:0] a, input logic [7:0] d, input logic w,
                         input logic r, input logic [47:0] pins, input string tag);
        int g, s;
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r; pin_in = pins;
        @(posedge clk);
        if (r) m_rd = m_read(a, pins);
        if (w) begin
            g = a[2];
            s = a[1:0];
            if (s == 3) begin
                if (d[7]) begin
                    m_ctl[g] = d;
                    for (int k = 0; k < 3; k++) m_lat[g*3+k] = 8'h00;
                end else begin
                    m_lat[g*3+2][d[3:1]] = d[0];
                end
            end else begin
                m_lat[g*3+s] = d;
            end
        end
        @(negedge clk);
        check(tag);
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d, input string tag);
        cycle(a, d, 1'b1, 1'b0, pin_in, tag);
    endtask

    task automatic rd(input logic [2:0] a, input logic [47:0] pins, input string tag);
        cycle(a, 8'h00, 1'b0, 1'b1, pins, tag);
    endtask

    initial begin
        #2000000;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int k = 0; k < 6; k++) m_lat[k] = 8'h00;
        m_ctl[0] = 8'h9B; m_ctl[1] = 8'h9B; m_rd = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 reset outputs");
        rd(3'd3, 48'h0, "R1 ctrl0 reset");
        rd(3'd7, 48'h0, "R1 ctrl1 reset");
        // R6: all inputs, pins read back
        rd(3'd0, 48'h123456_A5C33C, "R6 input read A0");
        rd(3'd6, 48'h9A5678_000000, "R6 input read C1");
        // R5: write to input port loads latch but does not drive
        wr(3'd1, 8'h77, "R5 latch while input");
        rd(3'd1, 48'h0000_0000_1100, "R5 input port reads pin");
        // R4: all outputs on group 0
        wr(3'd3, 8'h80, "R4 all outputs g0");
        wr(3'd0, 8'hA5, "R5 port A0 write");
        wr(3'd1, 8'h3C, "R5 port B0 write");
        wr(3'd2, 8'hF0, "R5 port C0 write");
        rd(3'd1, 48'hFFFF_FFFF_FFFF, "R6 output reads latch");
        // R2: group 1 addresses
        wr(3'd7, 8'h80, "R2 R4 all outputs g1");
        wr(3'd4, 8'h11, "R2 port A1");
        wr(3'd5, 8'h55, "R2 port B1");
        wr(3'd6, 8'hC3, "R2 port C1");
        // R3: split port C, upper nibble input
        wr(3'd3, 8'h88, "R3 R7 split C g0");
        wr(3'd2, 8'h5A, "R3 C0 latch");
        rd(3'd2, 48'h0000_00F0_0000, "R3 split C read");
        rd(3'd2, 48'h0000_000F_0000, "R3 split C read low pins");
        // R8: ignored bits
        wr(3'd3, 8'hE6, "R8 bits 6 5 2 ignored");
        rd(3'd3, 48'h0, "R8 ctrl readback");
        wr(3'd3, 8'hF3, "R3 R8 mixed word");
        wr(3'd0, 8'hFF, "R3 A0 latch as input");
        rd(3'd0, 48'h0000_0000_0012, "R3 A0 input read");
        rd(3'd3, 48'h0, "R8 ctrl readback F3");
        // R7: group 1 direction word leaves group 0
        wr(3'd2, 8'h3C, "R7 setup C0");
        wr(3'd7, 8'h9B, "R7 clear g1 only");
        rd(3'd6, 48'hABCDEF_000000, "R7 g1 reads pins");
        // R9: bit set/reset on port C
        wr(3'd3, 8'h80, "R9 setup g0 outputs");
        wr(3'd3, 8'h0F, "R9 set C0 bit7");
        wr(3'd3, 8'h03, "R9 set C0 bit1");
        wr(3'd3, 8'h0E, "R9 clear C0 bit7");
        wr(3'd3, 8'h01, "R9 set C0 bit0");
        rd(3'd2, 48'h0, "R9 C0 read");
        rd(3'd3, 48'h0, "R9 ctrl unchanged");
        wr(3'd7, 8'h80, "R9 setup g1 outputs");
        wr(3'd7, 8'h09, "R9 set C1 bit4");
        // R10: hold without read
        wr(3'd0, 8'h42, "R10 write no read");
        cycle(3'd5, 8'h00, 1'b0, 1'b0, 48'hFFFF_FFFF_FFFF, "R10 idle hold");
        cycle(3'd1, 8'h00, 1'b0, 1'b0, 48'h0, "R10 idle hold 2");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule